// File: doc/BRIEF.md
# SPI Serial Byte-Memory Slave

This block is the serial slave side of an 8,192-byte nonvolatile byte memory. Writes complete at once and never report busy. A host selects the block with an active-low chip select. It then clocks in a one-byte command, and for memory commands a two-byte address. After that, data moves in either direction. Input bits are taken on the rising serial-clock edge and output bits change on the falling edge, so a host can idle the clock either low or high between transfers.

All serial pins are sampled by the block's own system clock through a synchronizer. An edge detector turns the sampled serial clock into rise and fall events. A command engine then decodes the byte stream and moves data to and from an internal byte array. The address pointer steps after every byte and wraps at the top of the array.

A hold input pauses a transfer without deselecting the block. A write-protect pin, combined with a stored protect-enable bit, can lock the status register against writes. The serial clock half-period must span at least four system-clock cycles.

Top module: `spi_mem_slave`

## Requirements
- R1: While chip select is high the output enable stays low, and serial clock or data activity seen during that time changes no state. After reset the status byte reads 0x00.
- R2: Command 0x06 sets the write-enable latch and 0x04 clears it. Command 0x05 returns the status byte with the protect-enable bit in bit 7, the write-enable latch in bit 1 and zeros elsewhere. The status byte repeats for as long as it is clocked.
- R3: Command 0x02 writes memory bytes only while the write-enable latch is set. With the latch clear, the written bytes leave the array unchanged.
- R4: Commands 0x03 (read) and 0x02 (write) take a 16-bit address, most significant byte first. The top 3 bits of that address are ignored, and data bytes go to or come from consecutive addresses.
- R5: The address pointer wraps from 0x1FFF to 0x0000 for both reads and writes.
- R6: The write-enable latch clears when chip select rises after a 0x02 or 0x01 command.
- R7: Command 0x01 loads status bit 7 only when the latch is set. The load is also refused while the write-protect pin is low and the stored protect-enable bit is 1.
- R8: Transfers work both with the serial clock idling low and with it idling high.
- R9: While hold is low with chip select low, the output enable is low and clock edges are ignored. When hold returns high, the transfer continues bit-exactly from where it stopped.
- R10: A data byte cut short by chip select rising is not written, and the bytes before it are kept.
- R11: The output is driven only during the data phase of a 0x03 or 0x05 command, with each bit steady from one falling edge to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data into the block |
| hold_n | input | 1 | Pause request, active low |
| wp_n | input | 1 | Status write-protect pin, active low |
| so | output | 1 | Serial data out of the block |
| so_oe | output | 1 | Output enable for so (high = drive) |

## Verification
The assertions check on every cycle the following properties:
- The output enable is never raised outside a read data phase.
- A held, selected transfer keeps its state, bit count and shift register frozen.
- The write-enable latch is cleared after a write command is deselected.
- An array write never happens without a latch that was set the cycle before.
- A locked protect-enable bit cannot fall.

The bench scenarios cover what needs whole transactions:
- address masking and wrap-around
- discarding a truncated byte
- bit-exact resumption after a hold
- both clock idle levels
- the ordering of latch, pin and stored bit in status writes

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    localparam int BYTE_W  = 8;
    localparam int BCNT_W  = $clog2(BYTE_W);

    localparam logic [BYTE_W-1:0] OP_WREN = 8'h06;
    localparam logic [BYTE_W-1:0] OP_WRDI = 8'h04;
    localparam logic [BYTE_W-1:0] OP_RDSR = 8'h05;
    localparam logic [BYTE_W-1:0] OP_WRSR = 8'h01;
    localparam logic [BYTE_W-1:0] OP_READ = 8'h03;
    localparam logic [BYTE_W-1:0] OP_WRIT = 8'h02;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_RDSR,
        ST_WRSR,
        ST_SKIP
    } xfer_state_e;

    // one system-clock view of the serial pins
    typedef struct packed {
        logic sel;    // chip selected
        logic run;    // selected and not held
        logic rise;   // qualified rising serial clock edge
        logic fall;   // qualified falling serial clock edge
        logic si;     // serial data bit
        logic wp_ok;  // write-protect pin released (high)
    } spi_ev_t;

    function automatic logic [BYTE_W-1:0] status_byte(input logic wpen, input logic wel);
        return {wpen, 5'b00000, wel, 1'b0};
    endfunction

    function automatic logic is_out_state(input xfer_state_e s);
        return (s == ST_RDATA) || (s == ST_RDSR);
    endfunction

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
    parameter int           W       = 5,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            logic [W-1:0] r;
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) r <= RST_VAL;
                    else     r <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) r <= RST_VAL;
                    else     r <= g_stage[s-1].r;
                end
            end
        end
    endgenerate

    assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/spi_mem_edge.sv
module spi_mem_edge
    import spi_mem_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_n_s,
    input  logic    sck_s,
    input  logic    si_s,
    input  logic    hold_n_s,
    input  logic    wp_n_s,
    output spi_ev_t ev
);

    logic sck_q;

    // track the clock level at all times so activity during hold or
    // standby never shows up later as a stale edge
    always_ff @(posedge clk) begin
        if (rst) sck_q <= 1'b0;
        else     sck_q <= sck_s;
    end

    always_comb begin
        ev.sel   = !cs_n_s;
        ev.run   = !cs_n_s && hold_n_s;
        ev.rise  = ev.run && sck_s && !sck_q;
        ev.fall  = ev.run && !sck_s && sck_q;
        ev.si    = si_s;
        ev.wp_ok = wp_n_s;
    end

endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [BYTE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  spi_ev_t           ev,
    input  logic [BYTE_W-1:0] rdata,
    output logic [ADDR_W-1:0] raddr_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              so_o,
    output logic              so_oe_o
);

    localparam int HI_W = ADDR_W - BYTE_W;

    xfer_state_e       st_q;
    logic [BCNT_W-1:0] bit_cnt_q;
    logic [BYTE_W-1:0] shift_q;
    logic [BYTE_W-1:0] shift_nxt;
    logic [ADDR_W-1:0] addr_q;
    logic [HI_W-1:0]   addr_hi_q;
    logic              addr_byte_q;
    logic              is_rd_q;
    logic              load_q;
    logic              out_on_q;
    logic [BCNT_W-1:0] ocnt_q;
    logic [BYTE_W-1:0] out_byte_q;
    logic              so_q;
    logic              wel_q;
    logic              wpen_q;
    logic              wr_seen_q;
    logic              we_q;
    logic [ADDR_W-1:0] wa_q;
    logic [BYTE_W-1:0] wd_q;

    assign shift_nxt = {shift_q[BYTE_W-2:0], ev.si};

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_CMD;
            bit_cnt_q   <= '0;
            shift_q     <= '0;
            addr_q      <= '0;
            addr_hi_q   <= '0;
            addr_byte_q <= 1'b0;
            is_rd_q     <= 1'b0;
            load_q      <= 1'b0;
            out_on_q    <= 1'b0;
            ocnt_q      <= '0;
            out_byte_q  <= '0;
            so_q        <= 1'b0;
            wel_q       <= 1'b0;
            wpen_q      <= 1'b0;
            wr_seen_q   <= 1'b0;
            we_q        <= 1'b0;
            wa_q        <= '0;
            wd_q        <= '0;
        end else begin
            we_q <= 1'b0;
            if (!ev.sel) begin
                // standby: every selection restarts at the command byte
                st_q        <= ST_CMD;
                bit_cnt_q   <= '0;
                addr_byte_q <= 1'b0;
                load_q      <= 1'b0;
                out_on_q    <= 1'b0;
                ocnt_q      <= '0;
                if (wr_seen_q) wel_q <= 1'b0;
                wr_seen_q   <= 1'b0;
            end else begin
                if (load_q) begin
                    out_byte_q <= rdata;
                    addr_q     <= addr_q + 1'b1;
                    load_q     <= 1'b0;
                end
                if (ev.rise) begin
                    shift_q   <= shift_nxt;
                    bit_cnt_q <= bit_cnt_q + 1'b1;
                    if (bit_cnt_q == BCNT_W'(BYTE_W - 1)) begin
                        case (st_q)
                            ST_CMD: begin
                                case (shift_nxt)
                                    OP_WREN: begin
                                        wel_q <= 1'b1;
                                        st_q  <= ST_SKIP;
                                    end
                                    OP_WRDI: begin
                                        wel_q <= 1'b0;
                                        st_q  <= ST_SKIP;
                                    end
                                    OP_RDSR: begin
                                        out_byte_q <= status_byte(wpen_q, wel_q);
                                        st_q       <= ST_RDSR;
                                    end
                                    OP_WRSR: begin
                                        wr_seen_q <= 1'b1;
                                        st_q      <= ST_WRSR;
                                    end
                                    OP_READ: begin
                                        is_rd_q <= 1'b1;
                                        st_q    <= ST_ADDR;
                                    end
                                    OP_WRIT: begin
                                        is_rd_q   <= 1'b0;
                                        wr_seen_q <= 1'b1;
                                        st_q      <= ST_ADDR;
                                    end
                                    default: st_q <= ST_SKIP;
                                endcase
                            end
                            ST_ADDR: begin
                                if (!addr_byte_q) begin
                                    addr_hi_q   <= shift_nxt[HI_W-1:0];
                                    addr_byte_q <= 1'b1;
                                end else begin
                                    addr_q <= {addr_hi_q, shift_nxt};
                                    if (is_rd_q) begin
                                        load_q <= 1'b1;
                                        st_q   <= ST_RDATA;
                                    end else begin
                                        st_q <= ST_WDATA;
                                    end
                                end
                            end
                            ST_WDATA: begin
                                if (wel_q) begin
                                    we_q   <= 1'b1;
                                    wa_q   <= addr_q;
                                    wd_q   <= shift_nxt;
                                    addr_q <= addr_q + 1'b1;
                                end
                            end
                            ST_WRSR: begin
                                if (wel_q && (ev.wp_ok || !wpen_q))
                                    wpen_q <= shift_nxt[BYTE_W-1];
                                st_q <= ST_SKIP;
                            end
                            default: ;
                        endcase
                    end
                end
                if (ev.fall && is_out_state(st_q)) begin
                    out_on_q <= 1'b1;
                    so_q     <= out_byte_q[BCNT_W'(BYTE_W - 1) - ocnt_q];
                    ocnt_q   <= ocnt_q + 1'b1;
                    if (ocnt_q == BCNT_W'(BYTE_W - 1)) begin
                        if (st_q == ST_RDATA) begin
                            out_byte_q <= rdata;
                            addr_q     <= addr_q + 1'b1;
                        end else begin
                            out_byte_q <= status_byte(wpen_q, wel_q);
                        end
                    end
                end
            end
        end
    end

    assign raddr_o   = addr_q;
    assign wr_en_o   = we_q;
    assign wr_addr_o = wa_q;
    assign wr_data_o = wd_q;
    assign so_o      = so_q;
    assign so_oe_o   = ev.run && out_on_q;

    AST_STANDBY_RESTART: assert property (@(posedge clk) disable iff (rst)
        !ev.sel |=> (st_q == ST_CMD && bit_cnt_q == '0)); // R1

    AST_WRITE_NEEDS_LATCH: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> $past(wel_q)); // R3

    AST_LATCH_DROP: assert property (@(posedge clk) disable iff (rst)
        (!ev.sel && wr_seen_q) |=> !wel_q); // R6

    AST_PROTECT_LOCK: assert property (@(posedge clk) disable iff (rst)
        (wpen_q && !ev.wp_ok) |=> wpen_q); // R7

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (ev.sel && !ev.run) |=> (!ev.sel || ($stable(st_q) && $stable(bit_cnt_q) && $stable(shift_q)))); // R9

    AST_DRIVE_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
        so_oe_o |-> is_out_state(st_q)); // R11

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    input  logic wp_n,
    output logic so,
    output logic so_oe
);

    localparam int PIN_W = 5;
    localparam logic [PIN_W-1:0] PIN_IDLE = 5'b10011;

    logic [PIN_W-1:0]  pins_s;
    spi_ev_t           ev;
    logic [ADDR_W-1:0] raddr;
    logic [BYTE_W-1:0] rdata;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [BYTE_W-1:0] wr_data;

    spi_mem_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n, sck, si, hold_n, wp_n}),
        .q   (pins_s)
    );

    spi_mem_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .cs_n_s   (pins_s[4]),
        .sck_s    (pins_s[3]),
        .si_s     (pins_s[2]),
        .hold_n_s (pins_s[1]),
        .wp_n_s   (pins_s[0]),
        .ev       (ev)
    );

    spi_mem_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .rdata     (rdata),
        .raddr_o   (raddr),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .so_o      (so),
        .so_oe_o   (so_oe)
    );

    spi_mem_array #(.ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (rdata)
    );

endmodule

// File: tb/tb_spi_mem_slave.sv
module tb_spi_mem_slave;

    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
    logic so, so_oe;

    always #10 clk = ~clk;

    spi_mem_slave dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
        .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe)
    );

    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    bit   mode3 = 1'b0;
    logic [7:0] ref_mem [8192];
    bit   ref_wel = 1'b0;
    bit   ref_wpen = 1'b0;
    logic oe_all, oe_any;
    int   idle_cnt = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_h();
        repeat (HALF) @(negedge clk);
    endtask

    // one byte, most significant bit first; optional hold after bit hold_at
    task automatic xfer(input logic [7:0] tx, input int hold_at, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0;
            si  = tx[i];
            wait_h();
            rx[i]  = so;
            oe_all = oe_all & so_oe;
            oe_any = oe_any | so_oe;
            if (i == hold_at) begin
                hold_n = 1'b0;
                wait_h();
                chk("R9 output off while held", {31'b0, so_oe}, 32'd0);
                for (int k = 0; k < 3; k++) begin
                    sck = 1'b1; si = ~si; wait_h();
                    sck = 1'b0; wait_h();
                end
                si = tx[i];
                hold_n = 1'b1;
                wait_h();
            end
            sck = 1'b1;
            wait_h();
        end
    endtask

    task automatic begin_tx();
        sck = mode3;
        wait_h();
        oe_all = 1'b1;
        oe_any = 1'b0;
        cs_n = 1'b0;
        wait_h();
    endtask

    task automatic end_tx();
        if (!mode3) sck = 1'b0;
        wait_h();
        cs_n = 1'b1;
        repeat (4) wait_h();
    endtask

    task automatic op1(input logic [7:0] op);
        logic [7:0] rx;
        begin_tx(); xfer(op, -1, rx); end_tx();
        if (op == 8'h06) ref_wel = 1'b1;
        if (op == 8'h04) ref_wel = 1'b0;
    endtask

    task automatic chk_sr(input string req);
        logic [7:0] rx, s0, s1;
        begin_tx();
        xfer(8'h05, -1, rx);
        xfer(8'h00, -1, s0);
        xfer(8'h00, -1, s1);
        end_tx();
        chk(req, {24'b0, s0}, {24'b0, ref_wpen, 5'b0, ref_wel, 1'b0});
        chk({req, " repeated"}, {24'b0, s1}, {24'b0, s0});
    endtask

    task automatic wr_sr(input logic [7:0] v);
        logic [7:0] rx;
        begin_tx(); xfer(8'h01, -1, rx); xfer(v, -1, rx); end_tx();
        if (ref_wel && !(ref_wpen && !wp_n)) ref_wpen = v[7];
        ref_wel = 1'b0;
    endtask

    task automatic mem_wr(input logic [15:0] a, input logic [7:0] d[$],
                          input int hold_byte, input int extra_bits);
        logic [7:0] rx;
        logic [12:0] p;
        begin_tx();
        xfer(8'h02, -1, rx);
        xfer(a[15:8], -1, rx);
        xfer(a[7:0], -1, rx);
        foreach (d[i]) xfer(d[i], (i == hold_byte) ? 4 : -1, rx);
        for (int k = 0; k < extra_bits; k++) begin
            sck = 1'b0; si = 1'b1; wait_h();
            sck = 1'b1; wait_h();
        end
        end_tx();
        chk("R11 no drive during write", {31'b0, oe_any}, 32'd0);
        p = a[12:0];
        if (ref_wel) begin
            foreach (d[i]) begin
                ref_mem[p] = d[i];
                p = p + 13'd1;
            end
        end
        ref_wel = 1'b0;
    endtask

    task automatic mem_rd(input logic [15:0] a, input int n, input int hold_byte, input string req);
        logic [7:0] rx;
        logic [12:0] p;
        begin_tx();
        xfer(8'h03, -1, rx);
        xfer(a[15:8], -1, rx);
        xfer(a[7:0], -1, rx);
        oe_all = 1'b1;
        p = a[12:0];
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, (i == hold_byte) ? 3 : -1, rx);
            chk(req, {24'b0, rx}, {24'b0, ref_mem[p]});
            p = p + 13'd1;
        end
        chk("R11 driven during read data", {31'b0, oe_all}, 32'd1);
        end_tx();
    endtask

    // standby output check on every clock
    always @(negedge clk) begin
        if (rst || !cs_n) idle_cnt = 0;
        else begin
            idle_cnt++;
            if (idle_cnt >= 4) chk("R1 standby output off", {31'b0, so_oe}, 32'd0);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 output off after reset", {31'b0, so_oe}, 32'd0);
        chk_sr("R1 status after reset");

        // activity while deselected must be ignored
        for (int k = 0; k < 20; k++) begin
            si = k[0]; sck = ~sck; wait_h();
        end
        chk_sr("R1 standby ignores pins");

        op1(8'h06);
        chk_sr("R2 latch set");
        op1(8'h04);
        chk_sr("R2 latch cleared");

        op1(8'h06);
        mem_wr(16'h0010, '{8'h5A}, -1, 0);
        mem_wr(16'h0010, '{8'hA5}, -1, 0);
        mem_rd(16'h0010, 1, -1, "R3 write without latch ignored");

        op1(8'h06);
        mem_wr(16'hE005, '{8'h11, 8'h22, 8'h33, 8'h44}, -1, 0);
        chk_sr("R6 latch cleared after write");
        mem_rd(16'h0005, 4, -1, "R4 masked address sequential");

        op1(8'h06);
        mem_wr(16'h1FFE, '{8'hC1, 8'hC2, 8'hC3}, -1, 0);
        mem_rd(16'hFFFF, 2, -1, "R5 read wraps");
        mem_rd(16'h0000, 1, -1, "R5 write wrapped to zero");

        op1(8'h06);
        wr_sr(8'h80);
        chk_sr("R7 protect bit set");
        wp_n = 1'b0;
        op1(8'h06);
        wr_sr(8'h00);
        chk_sr("R7 locked by pin and bit");
        wp_n = 1'b1;
        op1(8'h06);
        wr_sr(8'h00);
        chk_sr("R7 unlocked with pin high");
        wp_n = 1'b0;
        op1(8'h06);
        wr_sr(8'h80);
        chk_sr("R7 pin low alone does not lock");
        wp_n = 1'b1;
        op1(8'h06);
        wr_sr(8'h00);
        wr_sr(8'h80);
        chk_sr("R7 needs latch");

        op1(8'h06);
        mem_wr(16'h0100, '{8'h3C, 8'hC3}, 0, 0);
        mem_rd(16'h0100, 2, 1, "R9 resume after hold");

        op1(8'h06);
        mem_wr(16'h0200, '{8'h01, 8'h02}, -1, 0);
        op1(8'h06);
        mem_wr(16'h0200, '{8'h77}, -1, 5);
        mem_rd(16'h0200, 2, -1, "R10 partial byte dropped");

        mode3 = 1'b1;
        op1(8'h06);
        mem_wr(16'h0300, '{8'h9A, 8'hBC}, -1, 0);
        chk_sr("R8 status in idle-high mode");
        mem_rd(16'h0300, 2, -1, "R8 idle-high read");
        mode3 = 1'b0;
        mem_rd(16'h0300, 2, -1, "R8 idle-low read back");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule